// File: doc/BRIEF.md
# Opcode-Driven Watchdog Timer

This block is a watchdog that software controls only by executing two dedicated instructions. The instruction decoder hands it one-cycle strobes. A refresh strobe arms the watchdog the first time it arrives and restarts the count every time after that. A halt-permit strobe lets the count continue while the core is halted, but only once the watchdog is armed. After arming, no instruction can turn the watchdog off. A configuration input can force it on from reset. When forced on, it also counts in the halted and stopped power states.

Each refresh strobe is answered on the next cycle with a flag-load request carrying fixed zero, sign and overflow values for the core's flag register. If the count runs a full timeout period without a refresh, the block raises a one-cycle reset request. It then holds a stretched reset output for a power-on-length interval plus a fixed number of extra oscillator cycles. While that reset is held, the count is frozen and strobes are ignored. Counting restarts from zero when the reset ends.

Top module: `insn_wdt`

## Requirements
- R1: After synchronous reset with `perm_en`=0, `wdt_rst_req`, `rst_out`, `flag_load` and `flag_z` read 0. No reset request ever appears until a refresh strobe has been seen.
- R2: The first `wdt_op` strobe arms the watchdog. `wdt_op` is sampled on edge P0. The counter then advances on each later counting edge. On the TIMEOUT_CYC-th counting edge the count reaches its limit, and `wdt_rst_req` is high for exactly the one following cycle (observed after edge P(TIMEOUT_CYC) in run state).
- R3: A `wdt_op` strobe on an armed watchdog clears the count. The next timeout comes TIMEOUT_CYC counting edges after that strobe's edge.
- R4: No strobe disarms the watchdog. A `halt_op` strobe neither disarms nor clears the count.
- R5: A `halt_op` strobe seen while the watchdog is not armed has no effect. A later refresh still leaves the count frozen in halt.
- R6: With `pwr_state`=2'b01 (halt), the count holds its value unless a halt permit is held or `perm_en`=1. The count resumes from the held value on return to `pwr_state`=2'b00 (run).
- R7: With `pwr_state`=2'b10 or 2'b11 (stop), the count holds its value unless `perm_en`=1.
- R8: With `perm_en`=1, the watchdog counts from the release of reset with no strobe, in every power state.
- R9: `rst_out` rises together with `wdt_rst_req` and stays high for exactly POR_CYC+EXTRA_CYC cycles. While it is high, strobes are ignored and the count is held. The next timeout comes TIMEOUT_CYC counting edges after `rst_out` falls.
- R10: With `perm_en`=0, a watchdog reset clears both the armed state and the halt permit.
- R11: The cycle after an accepted `wdt_op` strobe, `flag_load`=1 with `flag_z`=1, `flag_s`=0 and `flag_v`=0. `flag_load` is 0 in every other cycle, including after `halt_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perm_en | input | 1 | Permanent-enable configuration option |
| pwr_state | input | 2 | 00 run, 01 halt, 10/11 stop |
| wdt_op | input | 1 | Refresh opcode executed (one-cycle strobe) |
| halt_op | input | 1 | Halt-permit opcode executed (one-cycle strobe) |
| wdt_rst_req | output | 1 | One-cycle timeout reset request |
| rst_out | output | 1 | Stretched reset pulse |
| flag_load | output | 1 | Load the flag values below into the core |
| flag_z | output | 1 | Zero flag value |
| flag_s | output | 1 | Sign flag value |
| flag_v | output | 1 | Overflow flag value |

## Verification
A per-cycle vector table arms the watchdog, refreshes it partway through the period, and places a halt-permit strobe later in the period. The exact timeout cycle then shows whether a refresh clears the count and whether a halt-permit strobe wrongly clears it. Directed runs split the count across run, halt and stop. The measured remainder on return to run tells apart freezing, continuing and restarting in low-power states. Further runs issue the halt-permit strobe before arming, issue strobes inside the stretched reset, and set the permanent-enable option, in order to separate the arming and permit rules. The stretch is timed cycle by cycle, and so is the first timeout after it.

// File: rtl/insn_wdt_pkg.sv
package insn_wdt_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_HALT = 2'b01,
    PWR_STOP = 2'b10,
    PWR_DEEP = 2'b11
  } pwr_e;
endpackage

// File: rtl/insn_wdt_arm.sv
module insn_wdt_arm (
  input  logic clk,
  input  logic rst,
  input  logic perm_en,
  input  logic busy,
  input  logic arm_stb,
  input  logic permit_stb,
  input  logic fire,
  output logic armed,
  output logic halt_ok
);
  logic en_q;
  logic hp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      hp_q <= 1'b0;
    end else if (fire) begin
      if (!perm_en) begin
        en_q <= 1'b0;
        hp_q <= 1'b0;
      end
    end else if (!busy) begin
      if (arm_stb)
        en_q <= 1'b1;
      if (permit_stb && (en_q || perm_en))
        hp_q <= 1'b1;
    end
  end

  assign armed   = en_q | perm_en;
  assign halt_ok = hp_q | perm_en;

  // R4: once armed, only a timeout can drop the armed state
  p_armed_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && !fire) |=> en_q);

  // R5: a permit strobe while unarmed leaves the permit clear
  p_permit_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
    (permit_stb && !en_q && !perm_en && !hp_q) |=> !hp_q);

  // R10: a timeout without the option clears the armed state
  p_fire_disarms_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && !perm_en) |=> !en_q);
endmodule

// File: rtl/insn_wdt_count.sv
module insn_wdt_count #(
  parameter int TIMEOUT_CYC = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_en,
  input  logic clr,
  output logic fire
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign fire = cnt_en && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || fire)
      cnt <= '0;
    else if (cnt_en)
      cnt <= cnt + 1'b1;
  end

  // R6: without enable or clear the count holds its value
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !clr) |=> (cnt == $past(cnt)));

  // R3: a clear always restarts the count from zero
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R2: the count never passes the timeout limit
  always_comb begin
    if (!rst) p_no_overflow_r2: assert (cnt <= LAST);
  end
endmodule

// File: rtl/insn_wdt_stretch.sv
module insn_wdt_stretch #(
  parameter int LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic req_q,
  output logic busy_q
);
  localparam int LEFT_W = (LEN > 2) ? $clog2(LEN) : 1;

  logic [LEFT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      left   <= '0;
    end else if (fire && !busy_q) begin
      req_q  <= 1'b1;
      busy_q <= 1'b1;
      left   <= LEFT_W'(LEN - 1);
    end else begin
      req_q <= 1'b0;
      if (busy_q) begin
        if (left == '0)
          busy_q <= 1'b0;
        else
          left <= left - 1'b1;
      end
    end
  end

  // R9: the stretched reset always starts with the request cycle
  p_rise_with_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> req_q);

  // R2: the request lasts a single cycle
  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
endmodule

// File: rtl/insn_wdt.sv
module insn_wdt
  import insn_wdt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 65536,
  parameter int POR_CYC     = 6,
  parameter int EXTRA_CYC   = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       perm_en,
  input  logic [1:0] pwr_state,
  input  logic       wdt_op,
  input  logic       halt_op,
  output logic       wdt_rst_req,
  output logic       rst_out,
  output logic       flag_load,
  output logic       flag_z,
  output logic       flag_s,
  output logic       flag_v
);
  localparam int STRETCH = POR_CYC + EXTRA_CYC;

  pwr_e pwr;
  logic armed, halt_ok, busy, fire, cnt_en, clr, state_ok;

  assign pwr = pwr_e'(pwr_state);

  always_comb begin
    unique case (pwr)
      PWR_RUN:  state_ok = 1'b1;
      PWR_HALT: state_ok = halt_ok;
      default:  state_ok = perm_en;
    endcase
  end

  assign cnt_en = armed && !busy && state_ok;
  assign clr    = wdt_op && !busy;

  insn_wdt_arm u_arm (
    .clk        (clk),
    .rst        (rst),
    .perm_en    (perm_en),
    .busy       (busy),
    .arm_stb    (wdt_op),
    .permit_stb (halt_op),
    .fire       (fire),
    .armed      (armed),
    .halt_ok    (halt_ok)
  );

  insn_wdt_count #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_count (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .clr    (clr),
    .fire   (fire)
  );

  insn_wdt_stretch #(.LEN(STRETCH)) u_stretch (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .req_q  (wdt_rst_req),
    .busy_q (busy)
  );

  assign rst_out = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_load <= 1'b0;
      flag_z    <= 1'b0;
      flag_s    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      flag_load <= clr;
      if (clr) begin
        flag_z <= 1'b1;
        flag_s <= 1'b0;
        flag_v <= 1'b0;
      end
    end
  end

  // R11: a flag load always carries Z=1, S=0, V=0
  p_flag_values_r11: assert property (@(posedge clk) disable iff (rst)
    flag_load |-> (flag_z && !flag_s && !flag_v));

  // R7: stop without the option never times out
  p_stop_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    ((pwr == PWR_STOP || pwr == PWR_DEEP) && !perm_en) |-> !fire);

  // R6: halt without a permit never times out
  p_halt_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (pwr == PWR_HALT && !halt_ok) |-> !fire);

  // R9: no timeout while the stretched reset is held
  p_no_fire_busy_r9: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> !fire);
endmodule

// File: tb/insn_wdt_test.sv
module insn_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 8;
  localparam int POR        = 6;
  localparam int EXTRA      = 18;
  localparam int STR        = POR + EXTRA;

  // row: {arm, permit, pwr[1:0], exp_req, exp_rst, exp_flag}
  // R2 arm at row 0, R3 refresh at row 6, R4 permit at row 10, R11 flag rows
  localparam logic [6:0] VEC [16] = '{
    7'b1_0_00_0_0_1, 7'b0_0_00_0_0_0, 7'b0_0_00_0_0_0, 7'b0_0_00_0_0_0,
    7'b0_0_00_0_0_0, 7'b0_0_00_0_0_0, 7'b1_0_00_0_0_1, 7'b0_0_00_0_0_0,
    7'b0_0_00_0_0_0, 7'b0_0_00_0_0_0, 7'b0_1_00_0_0_0, 7'b0_0_00_0_0_0,
    7'b0_0_00_0_0_0, 7'b0_0_00_0_0_0, 7'b0_0_00_1_1_0, 7'b0_0_00_0_1_0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic perm_en = 1'b0;
  logic [1:0] pwr_state = 2'b00;
  logic wdt_op = 1'b0;
  logic halt_op = 1'b0;
  logic wdt_rst_req, rst_out, flag_load, flag_z, flag_s, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_wdt #(.TIMEOUT_CYC(TMO), .POR_CYC(POR), .EXTRA_CYC(EXTRA)) uut (
    .clk(clk), .rst(rst), .perm_en(perm_en), .pwr_state(pwr_state),
    .wdt_op(wdt_op), .halt_op(halt_op), .wdt_rst_req(wdt_rst_req),
    .rst_out(rst_out), .flag_load(flag_load), .flag_z(flag_z),
    .flag_s(flag_s), .flag_v(flag_v)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic arm_pulse();
    wdt_op = 1'b1;
    @(negedge clk);
    wdt_op = 1'b0;
  endtask

  task automatic permit_pulse();
    halt_op = 1'b1;
    @(negedge clk);
    halt_op = 1'b0;
  endtask

  task automatic no_req_for(input string tag, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wdt_rst_req) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic expect_req_after(input string tag, input int n);
    int early = 0;
    for (int k = 0; k < n - 1; k++) begin
      @(negedge clk);
      if (wdt_rst_req) early++;
    end
    chk({tag, " early request"}, early, 0);
    @(negedge clk);
    chk({tag, " request on time"}, wdt_rst_req, 1);
  endtask

  // called on the negedge where the request is first seen
  task automatic finish_stretch(input string tag);
    int low = 0;
    for (int k = 0; k < STR - 1; k++) begin
      @(negedge clk);
      if (!rst_out) low++;
    end
    chk({tag, " stretch held"}, low, 0);
    @(negedge clk);
    chk({tag, " stretch ended"}, rst_out, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 wdt_rst_req", wdt_rst_req, 0);
    chk("R1 rst_out", rst_out, 0);
    chk("R1 flag_load", flag_load, 0);
    chk("R1 flag_z", flag_z, 0);
    no_req_for("R1 no timeout unarmed", 3 * TMO);

    // table: R2 R3 R4 R11
    for (int i = 0; i < 16; i++) begin
      wdt_op    = VEC[i][6];
      halt_op   = VEC[i][5];
      pwr_state = VEC[i][4:3];
      @(negedge clk);
      wdt_op  = 1'b0;
      halt_op = 1'b0;
      chk($sformatf("R2 R3 req row %0d", i), wdt_rst_req, int'(VEC[i][2]));
      chk($sformatf("R9 rst_out row %0d", i), rst_out, int'(VEC[i][1]));
      chk($sformatf("R11 flag_load row %0d", i), flag_load, int'(VEC[i][0]));
      if (VEC[i][0]) begin
        chk("R11 flag values", {29'd0, flag_z, flag_s, flag_v}, 3'b100);
      end
    end

    // R9: refresh during the stretch is ignored, exact length
    arm_pulse();
    chk("R9 rst_out during stretch", rst_out, 1);
    chk("R9 strobe ignored, no flags", flag_load, 0);
    begin
      int low = 0;
      for (int k = 0; k < STR - 3; k++) begin
        @(negedge clk);
        if (!rst_out) low++;
      end
      chk("R9 stretch held", low, 0);
    end
    @(negedge clk);
    chk("R9 stretch length", rst_out, 0);

    // R10: disarmed after timeout
    no_req_for("R10 disarmed after timeout", 3 * TMO);
    // R10: halt permit cleared too
    arm_pulse();
    pwr_state = 2'b01;
    no_req_for("R10 permit cleared", 3 * TMO);
    pwr_state = 2'b00;
    expect_req_after("R10 rearm counts from zero", TMO);
    finish_stretch("R10");

    // R5: permit before arming has no effect
    permit_pulse();
    arm_pulse();
    pwr_state = 2'b01;
    no_req_for("R5 early permit ignored", 3 * TMO);
    pwr_state = 2'b00;
    expect_req_after("R5 run after halt", TMO);
    finish_stretch("R5");

    // R6 R7: halt and stop freeze the count, run resumes it
    arm_pulse();
    repeat (3) @(negedge clk);
    pwr_state = 2'b01;
    no_req_for("R6 halt frozen", 2 * TMO);
    pwr_state = 2'b10;
    no_req_for("R7 stop frozen", 2 * TMO);
    pwr_state = 2'b11;
    no_req_for("R7 stop code 11 frozen", TMO);
    pwr_state = 2'b00;
    expect_req_after("R6 resume from held count", TMO - 3);
    finish_stretch("R6");

    // R6: permit after arming lets halt count
    arm_pulse();
    permit_pulse();
    pwr_state = 2'b01;
    expect_req_after("R6 permitted halt counts", TMO - 1);
    finish_stretch("R6 permitted");
    pwr_state = 2'b00;

    // R8: permanent option counts from reset in stop
    rst = 1'b1;
    perm_en = 1'b1;
    pwr_state = 2'b10;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expect_req_after("R8 permanent in stop", TMO);
    finish_stretch("R8");
    // R9: restart from zero after stretch
    expect_req_after("R9 restart from zero", TMO);
    finish_stretch("R9 second");
    pwr_state = 2'b01;
    expect_req_after("R8 permanent in halt", TMO);
    finish_stretch("R8 halt");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule